// File: doc/BRIEF.md
# Presence Poll Controller with Absence Qualification

This controller watches a single-wire reader port for a device being put on it. It asks a lower-level reset generator for a reset/presence probe at a fixed interval. From each probe it receives a presence flag and a short flag. The aim is to detect a fresh arrival only after the previous device has clearly gone. A device sitting on a bouncing contact must not be seen as two arrivals.

Before detection is armed, a run of probes must pass with no presence response. This run is tracked by an absence counter. A clean presence reloads the counter to its start value. A clean absence lowers it by one. When the counter reaches zero, the controller arms. Once armed, it keeps probing until a clean presence arrives. It then raises a one-cycle arrival pulse and stops probing. The controller stays in that state until the transaction logic signals it is done, and then it starts qualifying absence again. A probe that reports a short is counted as neither presence nor absence, because a shorted bus can look like a presence response.

In the target use, a probe is about 1 ms long and is issued about every 50 ms. The probe period in clock cycles and the start value of the absence count are both parameters.

Top module: `presence_poll_ctrl`

## Requirements
- R1: After reset, `phase_o` is 0 (qualifying absence), and `arrival_o` and `probe_req_o` are low.
- R2: In phase 0 or 1, `probe_req_o` is a one-cycle pulse. The first pulse comes PROBE_PERIOD cycles after reset is released. Each later pulse comes PROBE_PERIOD cycles after the previous one, provided its result came back in time. No new request is made while a result is still outstanding.
- R3: In phase 0, a result with `presence_i`=0 and `short_i`=0 lowers the absence count by one. The ABSENCE_INIT-th such result in a row moves `phase_o` to 1 (armed) on the clock edge that accepts that result.
- R4: In phase 0, a result with `presence_i`=1 and `short_i`=0 reloads the absence count to ABSENCE_INIT. A full ABSENCE_INIT further absences are then needed before the controller arms.
- R5: A result with `short_i`=1 leaves the absence count and `phase_o` unchanged, whatever the value of `presence_i`. In particular it never produces an arrival.
- R6: In phase 1, an absence result keeps the phase at 1. The first result with `presence_i`=1 and `short_i`=0 raises `arrival_o` for exactly one cycle and sets `phase_o` to 2 (device present) on the edge that accepts it.
- R7: In phase 2, no probes are requested. A `done_i` pulse returns `phase_o` to 0 with the absence count reloaded. The next request follows PROBE_PERIOD cycles after that edge.
- R8: A `probe_done_i` pulse with no outstanding request is ignored. A `done_i` pulse outside phase 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_req_o | output | 1 | One-cycle request for a reset/presence probe |
| probe_done_i | input | 1 | Probe result valid, one cycle |
| presence_i | input | 1 | A presence response was seen during the probe |
| short_i | input | 1 | The probe found the bus shorted |
| done_i | input | 1 | The transaction with the present device has finished |
| arrival_o | output | 1 | One-cycle pulse when an arrival is detected |
| phase_o | output | 2 | Phase: 0 qualifying absence, 1 armed, 2 device present |

## Verification
The absence count is not visible at the ports. A wrong count shows up as arming too early or too late. The bench's reference model catches this on the exact result that should, or should not, move `phase_o` to 1. A skipped or doubled decrement is therefore reported on that probe. A timer or outstanding-request fault shows up as a shifted or extra `probe_req_o`, and is caught at the next request through the spacing check. A leak of short or spurious results is forced into view by putting those results where the count is one step from arming, or where the controller is armed. There, a wrong update changes `phase_o` or `arrival_o` on the very next cycle.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    PH_QUAL    = 2'd0,
    PH_ARMED   = 2'd1,
    PH_PRESENT = 2'd2
  } phase_e;
endpackage

// File: rtl/probe_timer.sv
module probe_timer #(
  parameter int unsigned PERIOD = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic result_i,
  output logic req_o,
  output logic pending_o
);
  localparam int unsigned TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(PERIOD - 1);

  logic [TW-1:0] tmr_q;
  logic          busy_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= RELOAD;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (restart_i) begin
        tmr_q  <= RELOAD;
        busy_q <= 1'b0;
      end else begin
        if (result_i) busy_q <= 1'b0;
        if (en_i) begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (!busy_q) begin
            req_q  <= 1'b1;
            busy_q <= 1'b1;
            tmr_q  <= RELOAD;
          end
        end
      end
    end
  end

  assign req_o     = req_q;
  assign pending_o = busy_q;

  // R2: request is a single-cycle pulse
  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R2: no new request while one is outstanding
  assert_one_outstanding_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !result_i && !restart_i) |=> !req_o);
endmodule

// File: rtl/absence_counter.sv
module absence_counter #(
  parameter int unsigned INIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic miss_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(INIT + 1);
  localparam logic [CW-1:0] START = CW'(INIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= START;
    else if (reload_i)              cnt_q <= START;
    else if (miss_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = miss_i && !reload_i && (cnt_q == CW'(1));

  // R4: count stays within its start value
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= START);
  // R4: a reload always lands on the start value
  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == START);
endmodule

// File: rtl/presence_poll_ctrl.sv
module presence_poll_ctrl
  import poll_pkg::*;
#(
  parameter int unsigned PROBE_PERIOD = 50000,
  parameter int unsigned ABSENCE_INIT = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       probe_req_o,
  input  logic       probe_done_i,
  input  logic       presence_i,
  input  logic       short_i,
  input  logic       done_i,
  output logic       arrival_o,
  output logic [1:0] phase_o
);
  phase_e phase_q, phase_d;
  logic   arrival_q, pending, result_v, clean_pres, clean_abs;
  logic   cnt_reload, cnt_miss, cnt_expire, restart;

  assign result_v   = probe_done_i && pending;
  assign clean_pres = result_v && presence_i && !short_i;
  assign clean_abs  = result_v && !presence_i && !short_i;

  assign restart    = (phase_q == PH_PRESENT) && done_i;
  assign cnt_reload = ((phase_q == PH_QUAL) && clean_pres) || restart;
  assign cnt_miss   = (phase_q == PH_QUAL) && clean_abs;

  probe_timer #(.PERIOD(PROBE_PERIOD)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (phase_q != PH_PRESENT),
    .restart_i (restart),
    .result_i  (probe_done_i),
    .req_o     (probe_req_o),
    .pending_o (pending)
  );

  absence_counter #(.INIT(ABSENCE_INIT)) u_absence (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (cnt_reload),
    .miss_i   (cnt_miss),
    .expire_o (cnt_expire)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_QUAL:    if (cnt_expire) phase_d = PH_ARMED;
      PH_ARMED:   if (clean_pres) phase_d = PH_PRESENT;
      PH_PRESENT: if (done_i)     phase_d = PH_QUAL;
      default:    phase_d = PH_QUAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_QUAL;
      arrival_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      arrival_q <= (phase_q == PH_ARMED) && clean_pres;
    end
  end

  assign arrival_o = arrival_q;
  assign phase_o   = phase_q;

  // R6: arrival only on entry to present, and only from armed
  assert_arrival_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrival_o |-> (phase_q == PH_PRESENT) && ($past(phase_q) == PH_ARMED));
  assert_arrival_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrival_o |=> !arrival_o);
  // R5: a shorted probe never yields arrival or a phase change
  assert_short_no_arrival_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_v && short_i) |=> !arrival_o && $stable(phase_q));
  // R7: no probing while a device is present
  assert_quiet_present_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRESENT) |-> !probe_req_o);
  // R8: done outside present has no effect
  assert_done_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ARMED && done_i && !clean_pres) |=> phase_q == PH_ARMED);
endmodule

// File: tb/presence_poll_ctrl_bench.sv
module presence_poll_ctrl_bench;
  localparam int P = 12;
  localparam int A = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic probe_req, probe_done = 1'b0, presence = 1'b0, short_b = 1'b0, done = 1'b0;
  logic arrival;
  logic [1:0] phase;

  int checks = 0, failures = 0, cyc = 0, last_req = -1;
  int m_phase = 0, m_cnt = A;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  presence_poll_ctrl #(.PROBE_PERIOD(P), .ABSENCE_INIT(A)) u_presence_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .probe_req_o(probe_req), .probe_done_i(probe_done),
    .presence_i(presence), .short_i(short_b), .done_i(done),
    .arrival_o(arrival), .phase_o(phase));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  function automatic int next_phase(input int ph, input int cnt, input bit pr, input bit sh);
    if (sh) return ph;
    if (ph == 0 && !pr && cnt == 1) return 1;
    if (ph == 1 && pr) return 2;
    return ph;
  endfunction

  function automatic int next_cnt(input int ph, input int cnt, input bit pr, input bit sh);
    if (sh || ph != 0) return cnt;
    if (pr) return A;
    return cnt - 1;
  endfunction

  task automatic wait_req();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!probe_req && n < 1000);
    chk("R2 request seen", int'(probe_req), 1);
    if (last_req >= 0) chk("R2 request spacing", cyc - last_req, P);
    last_req = cyc;
  endtask

  task automatic finish_present();
    int quiet = 1;
    repeat ($urandom_range(5, 2 * P)) begin
      @(negedge clk);
      if (probe_req) quiet = 0;
    end
    chk("R7 no request while present", quiet, 1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    m_phase = 0;
    m_cnt = A;
    chk("R7 done returns to qualify", int'(phase), 0);
    last_req = cyc;
  endtask

  task automatic respond(input bit pr, input bit sh);
    int exp_ph;
    wait_req();
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      chk("R2 one outstanding", int'(probe_req), 0);
    end
    probe_done = 1'b1; presence = pr; short_b = sh;
    @(negedge clk);
    probe_done = 1'b0; presence = 1'b0; short_b = 1'b0;
    exp_ph = next_phase(m_phase, m_cnt, pr, sh);
    m_cnt  = next_cnt(m_phase, m_cnt, pr, sh);
    chk(sh ? "R5 phase after short" : (m_phase == 0 ? "R3 phase after result" : "R6 phase after result"),
        int'(phase), exp_ph);
    chk("R6 arrival", int'(arrival), (m_phase == 1 && exp_ph == 2) ? 1 : 0);
    if (m_phase == 1 && exp_ph == 2) begin
      @(negedge clk);
      chk("R6 arrival one cycle", int'(arrival), 0);
    end
    m_phase = exp_ph;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 phase at reset", int'(phase), 0);
    chk("R1 arrival at reset", int'(arrival), 0);
    chk("R1 request at reset", int'(probe_req), 0);
    rst_n = 1'b1;
    last_req = cyc;

    // R3: plain qualification, spurious result at count 1 (R8)
    for (int i = 0; i < A - 1; i++) respond(1'b0, 1'b0);
    probe_done = 1'b1;
    @(negedge clk);
    probe_done = 1'b0;
    chk("R8 spurious result ignored", int'(phase), 0);
    respond(1'b0, 1'b0);
    chk("R3 armed after full run", int'(phase), 1);
    respond(1'b1, 1'b0);
    finish_present();

    // R4: presence mid-run reloads the count
    for (int i = 0; i < A - 1; i++) respond(1'b0, 1'b0);
    respond(1'b1, 1'b0);
    for (int i = 0; i < A - 1; i++) respond(1'b0, 1'b0);
    chk("R4 still qualifying after reload", int'(phase), 0);
    respond(1'b0, 1'b0);
    chk("R4 armed after full new run", int'(phase), 1);

    // R5: shorts while armed, R8: done while armed
    respond(1'b1, 1'b1);
    respond(1'b0, 1'b1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R8 done ignored when armed", int'(phase), 1);
    respond(1'b1, 1'b0);
    finish_present();

    // R5: short at count 1 must not arm
    for (int i = 0; i < A - 1; i++) respond(1'b0, 1'b0);
    respond(1'b1, 1'b1);
    chk("R5 short at count one", int'(phase), 0);
    respond(1'b0, 1'b0);

    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 70)      respond(1'b0, 1'b0);
      else if (r < 85) respond(1'b1, 1'b0);
      else             respond(1'($urandom_range(0, 1)), 1'b1);
      if (m_phase == 2) finish_present();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule